// File: doc/BRIEF.md
# Four-Way Set-Associative Data Cache

This block holds 4 KB of data next to a processor's load/store port. Storage is split into four ways of 32 sets, and each line holds eight 32-bit words. Address bits [4:2] pick the word inside a line, bits [9:5] pick the set, and bits [31:10] are kept as the tag. A read that misses brings the whole line in from a word-wide memory port. A write that misses is forwarded to memory and leaves the cache untouched. Two run-time mode pins choose how a victim way is picked (rotating pointer or pseudo-random) and how write hits are handled (forwarded at once, or held in the line and marked dirty).

Each access carries a cacheable flag from the external protection check. Accesses with the flag low go to memory as single-word transfers. They never look up, fill or update the cache, so device registers always see their writes and always return live data. A one-cycle invalidate pulse drops every line and every dirty mark without writing anything back. The pulse is held until the block is idle.

Both the request and the response sides are valid/ready streams. The processor holds `req_*` stable while `req_valid` is high and `req_ready` is low. The block accepts one access at a time and lowers `req_ready` until the response has been taken. The block holds `rsp_valid` and `rsp_rdata` until `rsp_ready` is seen. On the memory side the block holds `mem_req_*` until `mem_req_ready`. Each accepted read gets exactly one `mem_rsp_valid` beat, which cannot be stalled. Only one memory read is outstanding at a time.

Top module: `dcache_top`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, `mem_req_valid` is 0, and every line is invalid.
- R2: A cacheable read miss issues exactly 8 memory reads, covering the whole line in word order 0..7, and returns the addressed word.
- R3: A cacheable read hit issues no memory transfer and returns the stored word.
- R4: A cacheable write miss issues exactly one memory write and no memory read, and allocates no line, so a later read of that address misses.
- R5: With `mode_wback`=0, a write hit updates the line and also issues exactly one memory write of the same word.
- R6: With `mode_wback`=1, a write hit updates the line, marks it dirty and issues no memory transfer. When a dirty line is chosen as victim, its 8 words are written to memory before the refill reads start.
- R7: A read with `req_cacheable`=0 issues exactly one memory read and returns that memory data, even when a stale copy of the line is cached.
- R8: A write with `req_cacheable`=0 issues exactly one memory write and leaves any cached copy unchanged.
- R9: With `mode_random`=0, victims rotate through the ways. The pointer advances once per line allocation, so five distinct lines read into one set evict the first of them.
- R10: With `mode_random`=1, victims come from a free-running LFSR. Reads always return correct data, and each read costs either 0 or 8 memory reads.
- R11: An `inv_all` pulse clears every valid and dirty mark with no write-back. A later read of a formerly dirty line refetches it from memory.
- R12: While `rsp_valid` is high and `rsp_ready` is low, the response and its data stay unchanged. `req_ready` stays low from acceptance until the response is taken, and `mem_req_*` holds while `mem_req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_random | input | 1 | 1 = pseudo-random victim choice, 0 = rotating pointer |
| mode_wback | input | 1 | 1 = write hits stay in the cache (dirty), 0 = write hits also go to memory |
| inv_all | input | 1 | Pulse that invalidates all lines without write-back |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block can accept an access |
| req_write | input | 1 | 1 = store, 0 = load |
| req_cacheable | input | 1 | Protection result; 0 forces a single-word memory bypass |
| req_addr | input | 32 | Byte address (word aligned) |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Access complete; load data valid |
| rsp_ready | input | 1 | Processor takes the response |
| rsp_rdata | output | 32 | Load data (0 for stores) |
| mem_req_valid | output | 1 | Memory transfer request valid |
| mem_req_ready | input | 1 | Memory accepts the transfer |
| mem_req_write | output | 1 | 1 = memory write, 0 = memory read |
| mem_req_addr | output | 32 | Memory word address in byte units |
| mem_req_wdata | output | 32 | Memory write data |
| mem_rsp_valid | input | 1 | Read data beat from memory |
| mem_rsp_rdata | input | 32 | Read data from memory |

## Verification
The checker assumes that memory returns exactly one `mem_rsp_valid` beat for each accepted read and no beat for writes, and that a new access never arrives while `req_ready` is low. The bench memory model answers every read one cycle after acceptance. The bench drives each access through a task that waits for `req_ready` and `rsp_valid`, so these assumptions hold throughout. The transfer-count checks assume that the cacheable flag and the mode pins stay fixed during an access; the bench changes them only between accesses.

// File: rtl/dcache_pkg.sv
`timescale 1ns/1ps
package dcache_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,   // waiting for an access
    ST_LOOK,   // tag compare on latched request
    ST_EVICT,  // writing a dirty victim back, one word per beat
    ST_FREQ,   // issue one refill read
    ST_FWAIT,  // wait for the refill beat
    ST_BREQ,   // bypass read request
    ST_BWAIT,  // bypass read data
    ST_MWR,    // single memory write (miss, bypass or write-through)
    ST_RESP    // hold response until taken
  } dc_state_t;
endpackage

// File: rtl/dcache_victim.sv
`timescale 1ns/1ps
module dcache_victim #(
  parameter int WAYS = 4,
  localparam int VW = $clog2(WAYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          use_random,
  input  logic          advance,
  output logic [VW-1:0] victim
);
  localparam int LW = 8;
  logic [LW-1:0] lfsr;
  logic [VW-1:0] rr;

  // maximal-length 8-bit sequence, runs every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr <= 8'h5B;
    else        lfsr <= {lfsr[LW-2:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rr <= '0;
    else if (advance) rr <= rr + 1'b1;
  end

  assign victim = use_random ? lfsr[VW-1:0] : rr;
endmodule

// File: rtl/dcache_way.sv
`timescale 1ns/1ps
module dcache_way #(
  parameter int SETS       = 32,
  parameter int LINE_WORDS = 8,
  parameter int TAG_W      = 22,
  parameter int DATA_W     = 32,
  localparam int SB = $clog2(SETS),
  localparam int WB = $clog2(LINE_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_all,
  input  logic [SB-1:0]     set_idx,
  input  logic [WB-1:0]     word_idx,
  input  logic [TAG_W-1:0]  cmp_tag,
  input  logic              wr_word,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              install,
  input  logic              mark_dirty,
  output logic              hit,
  output logic              valid_o,
  output logic              dirty_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [DATA_W-1:0] rdata
);
  logic [SETS-1:0]   vld;
  logic [SETS-1:0]   drt;
  logic [TAG_W-1:0]  tags [SETS];
  logic [DATA_W-1:0] words [SETS][LINE_WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      drt <= '0;
    end else if (clear_all) begin
      vld <= '0;
      drt <= '0;
    end else begin
      if (install) begin
        vld[set_idx] <= 1'b1;
        drt[set_idx] <= 1'b0;
      end
      if (mark_dirty) drt[set_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (install) tags[set_idx] <= cmp_tag;
    if (wr_word) words[set_idx][word_idx] <= wr_data;
  end

  assign valid_o = vld[set_idx];
  assign dirty_o = drt[set_idx];
  assign tag_o   = tags[set_idx];
  assign hit     = vld[set_idx] && (tags[set_idx] == cmp_tag);
  assign rdata   = words[set_idx][word_idx];
endmodule

// File: rtl/dcache_top.sv
`timescale 1ns/1ps
module dcache_top #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int WAYS       = 4,
  parameter int SETS       = 32,
  parameter int LINE_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_random,
  input  logic              mode_wback,
  input  logic              inv_all,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_cacheable,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata
);
  import dcache_pkg::*;

  localparam int VW    = $clog2(WAYS);
  localparam int SB    = $clog2(SETS);
  localparam int WB    = $clog2(LINE_WORDS);
  localparam int OFF   = WB + 2;
  localparam int TAG_W = ADDR_W - OFF - SB;
  localparam logic [WB-1:0] LAST = WB'(LINE_WORDS - 1);

  dc_state_t st;
  logic [ADDR_W-1:0] r_addr;
  logic [DATA_W-1:0] r_wdata, rsp_q;
  logic r_write, r_cache, inv_pend;
  logic [WB-1:0] cnt;
  logic [VW-1:0] vic, victim;

  logic [SB-1:0]    set_idx;
  logic [WB-1:0]    req_word, way_word;
  logic [TAG_W-1:0] req_tag;
  assign set_idx  = r_addr[OFF +: SB];
  assign req_word = r_addr[2 +: WB];
  assign req_tag  = r_addr[ADDR_W-1 -: TAG_W];
  assign way_word = (st == ST_EVICT || st == ST_FREQ || st == ST_FWAIT) ? cnt : req_word;

  logic [WAYS-1:0] way_hit, way_vld, way_drt, way_wr, way_inst, way_dirty_set;
  logic [TAG_W-1:0]  way_tag   [WAYS];
  logic [DATA_W-1:0] way_rdata [WAYS];
  logic [DATA_W-1:0] fill_data;
  logic do_inv, look_cache;

  assign do_inv     = (st == ST_IDLE) && (inv_all || inv_pend);
  assign look_cache = (st == ST_LOOK) && r_cache;
  assign fill_data  = (st == ST_FWAIT) ? mem_rsp_rdata : r_wdata;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign way_wr[w] = (look_cache && r_write && way_hit[w]) ||
                       (st == ST_FWAIT && mem_rsp_valid && vic == VW'(w));
    assign way_inst[w] = st == ST_FWAIT && mem_rsp_valid && cnt == LAST && vic == VW'(w);
    assign way_dirty_set[w] = look_cache && r_write && way_hit[w] && mode_wback;

    dcache_way #(.SETS(SETS), .LINE_WORDS(LINE_WORDS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_way (
      .clk(clk), .rst_n(rst_n), .clear_all(do_inv), .set_idx(set_idx), .word_idx(way_word),
      .cmp_tag(req_tag), .wr_word(way_wr[w]), .wr_data(fill_data), .install(way_inst[w]),
      .mark_dirty(way_dirty_set[w]), .hit(way_hit[w]), .valid_o(way_vld[w]),
      .dirty_o(way_drt[w]), .tag_o(way_tag[w]), .rdata(way_rdata[w]));
  end

  logic              hit_any;
  logic [DATA_W-1:0] hit_data;
  always_comb begin
    hit_any  = 1'b0;
    hit_data = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_hit[w]) begin
        hit_any  = 1'b1;
        hit_data = hit_data | way_rdata[w];
      end
    end
  end

  logic alloc;
  assign alloc = look_cache && !r_write && !hit_any;

  dcache_victim #(.WAYS(WAYS)) u_victim (
    .clk(clk), .rst_n(rst_n), .use_random(mode_random), .advance(alloc), .victim(victim));

  assign req_ready     = (st == ST_IDLE) && !inv_all && !inv_pend;
  assign rsp_valid     = (st == ST_RESP);
  assign rsp_rdata     = rsp_q;
  assign mem_req_valid = (st == ST_EVICT) || (st == ST_FREQ) || (st == ST_BREQ) || (st == ST_MWR);
  assign mem_req_write = (st == ST_EVICT) || (st == ST_MWR);
  assign mem_req_wdata = (st == ST_EVICT) ? way_rdata[vic] : r_wdata;

  always_comb begin
    case (st)
      ST_EVICT: mem_req_addr = {way_tag[vic], set_idx, cnt, 2'b00};
      ST_FREQ:  mem_req_addr = {req_tag, set_idx, cnt, 2'b00};
      default:  mem_req_addr = r_addr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;  r_addr <= '0;  r_wdata <= '0;  rsp_q <= '0;
      r_write <= 1'b0;  r_cache <= 1'b0;  inv_pend <= 1'b0;
      cnt <= '0;  vic <= '0;
    end else begin
      if (inv_all && st != ST_IDLE) inv_pend <= 1'b1;
      case (st)
        ST_IDLE: begin
          if (do_inv) inv_pend <= 1'b0;
          else if (req_valid) begin
            r_addr <= req_addr;  r_wdata <= req_wdata;
            r_write <= req_write;  r_cache <= req_cacheable;
            st <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          cnt <= '0;
          if (!r_cache)     st <= r_write ? ST_MWR : ST_BREQ;
          else if (r_write) begin
            rsp_q <= '0;
            st <= (hit_any && mode_wback) ? ST_RESP : ST_MWR;
          end else if (hit_any) begin
            rsp_q <= hit_data;
            st <= ST_RESP;
          end else begin
            vic <= victim;
            st  <= (way_vld[victim] && way_drt[victim]) ? ST_EVICT : ST_FREQ;
          end
        end
        ST_EVICT: if (mem_req_ready) begin
          if (cnt == LAST) begin cnt <= '0; st <= ST_FREQ; end
          else cnt <= cnt + 1'b1;
        end
        ST_FREQ: if (mem_req_ready) st <= ST_FWAIT;
        ST_FWAIT: if (mem_rsp_valid) begin
          if (cnt == req_word) rsp_q <= mem_rsp_rdata;
          if (cnt == LAST) st <= ST_RESP;
          else begin cnt <= cnt + 1'b1; st <= ST_FREQ; end
        end
        ST_BREQ: if (mem_req_ready) st <= ST_BWAIT;
        ST_BWAIT: if (mem_rsp_valid) begin rsp_q <= mem_rsp_rdata; st <= ST_RESP; end
        ST_MWR: if (mem_req_ready) begin
          if (r_write) rsp_q <= '0;
          st <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dcache_checker.sv
`timescale 1ns/1ps
module dcache_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr
);
  logic [3:0] rd_n, wr_n;
  logic       was_wr;

  // memory transfers issued since the current access was accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_n <= '0;  wr_n <= '0;  was_wr <= 1'b0;
    end else if (req_valid && req_ready) begin
      rd_n <= '0;  wr_n <= '0;  was_wr <= req_write;
    end else if (mem_req_valid && mem_req_ready) begin
      if (mem_req_write) wr_n <= wr_n + 1'b1;
      else               rd_n <= rd_n + 1'b1;
    end
  end

  p_rsp_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  p_mreq_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));

  p_busy_no_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  p_read_txn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready && !was_wr |->
      (rd_n == 4'd0 || rd_n == 4'd1 || rd_n == 4'd8) && (wr_n == 4'd0 || wr_n == 4'd8));

  p_write_txn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready && was_wr |-> rd_n == 4'd0 && wr_n <= 4'd1);
endmodule

bind dcache_top dcache_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr));

// File: tb/dcache_top_test.sv
`timescale 1ns/1ps
module dcache_top_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic mode_random = 0, mode_wback = 0, inv_all = 0;
  logic req_valid = 0, req_write = 0, req_cacheable = 0, rsp_ready = 1;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic req_ready, rsp_valid, mem_req_valid, mem_req_write;
  logic [31:0] rsp_rdata, mem_req_addr, mem_req_wdata;
  logic mem_req_ready = 1'b1, mem_rsp_valid = 1'b0, stall = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;

  dcache_top uut (.*);

  int checks = 0, errors = 0, rd_ops = 0, wr_ops = 0;
  logic [31:0] mem [4096];

  function automatic logic [31:0] seed(int i);
    return 32'h5A5A_0000 ^ (i * 32'h0001_0003);
  endfunction

  initial for (int i = 0; i < 4096; i++) mem[i] = seed(i);

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    mem_req_ready <= stall ? ~mem_req_ready : 1'b1;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_write) begin
        mem[mem_req_addr[13:2]] = mem_req_wdata;
        wr_ops <= wr_ops + 1;
      end else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= mem[mem_req_addr[13:2]];
        rd_ops <= rd_ops + 1;
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [31:0] a, input logic [31:0] d,
                        input logic c, output logic [31:0] q);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d; req_cacheable = c;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    q = rsp_rdata;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 req_ready", 32'(req_ready), 1);
    check("R1 rsp_valid", 32'(rsp_valid), 0);
    check("R1 mem_req_valid", 32'(mem_req_valid), 0);
  endtask

  task automatic t_miss_hit();
    logic [31:0] q; int r0;
    r0 = rd_ops;
    access(0, 32'h48, 0, 1, q);
    check("R2 data", q, mem[32'h48 >> 2]);
    check("R2 reads", 32'(rd_ops - r0), 8);
    r0 = rd_ops;
    access(0, 32'h5C, 0, 1, q);
    check("R3 data", q, mem[32'h5C >> 2]);
    check("R3 reads", 32'(rd_ops - r0), 0);
  endtask

  task automatic t_write_miss();
    logic [31:0] q; int r0, w0;
    r0 = rd_ops; w0 = wr_ops;
    access(1, 32'h460, 32'hCAFE_0001, 1, q);
    check("R4 writes", 32'(wr_ops - w0), 1);
    check("R4 reads", 32'(rd_ops - r0), 0);
    check("R4 mem", mem[32'h460 >> 2], 32'hCAFE_0001);
    r0 = rd_ops;
    access(0, 32'h460, 0, 1, q);
    check("R4 no alloc", 32'(rd_ops - r0), 8);
    check("R4 data", q, 32'hCAFE_0001);
  endtask

  task automatic t_write_through();
    logic [31:0] q; int r0, w0;
    mode_wback = 0;
    r0 = rd_ops; w0 = wr_ops;
    access(1, 32'h48, 32'h1111_2222, 1, q);
    check("R5 writes", 32'(wr_ops - w0), 1);
    check("R5 mem", mem[32'h48 >> 2], 32'h1111_2222);
    access(0, 32'h48, 0, 1, q);
    check("R5 data", q, 32'h1111_2222);
    check("R5 reads", 32'(rd_ops - r0), 0);
  endtask

  task automatic t_write_back_rr();
    logic [31:0] q, old0; int r0, w0;
    mode_wback = 1; mode_random = 0;
    for (int k = 0; k < 4; k++) access(0, 32'hA0 + k * 32'h400, 0, 1, q);
    old0 = mem[32'hA4 >> 2];
    w0 = wr_ops;
    access(1, 32'hA4, 32'hBEEF_0004, 1, q);
    check("R6 no write", 32'(wr_ops - w0), 0);
    check("R6 mem kept", mem[32'hA4 >> 2], old0);
    r0 = rd_ops; w0 = wr_ops;
    access(0, 32'hA0 + 4 * 32'h400, 0, 1, q);
    check("R6 evict writes", 32'(wr_ops - w0), 8);
    check("R6 refill reads", 32'(rd_ops - r0), 8);
    check("R6 written back", mem[32'hA4 >> 2], 32'hBEEF_0004);
    r0 = rd_ops;
    access(0, 32'hA0 + 32'h400, 0, 1, q);
    check("R9 second line kept", 32'(rd_ops - r0), 0);
    r0 = rd_ops;
    access(0, 32'hA4, 0, 1, q);
    check("R9 first line evicted", 32'(rd_ops - r0), 8);
    check("R9 data", q, 32'hBEEF_0004);
    mode_wback = 0;
  endtask

  task automatic t_bypass();
    logic [31:0] q; int r0, w0;
    mem[32'h48 >> 2] = 32'h7777_0000;
    r0 = rd_ops;
    access(0, 32'h48, 0, 0, q);
    check("R7 live data", q, 32'h7777_0000);
    check("R7 reads", 32'(rd_ops - r0), 1);
    w0 = wr_ops;
    access(1, 32'h48, 32'h8888_0000, 0, q);
    check("R8 writes", 32'(wr_ops - w0), 1);
    check("R8 mem", mem[32'h48 >> 2], 32'h8888_0000);
    r0 = rd_ops;
    access(0, 32'h48, 0, 1, q);
    check("R8 cache untouched", q, 32'h1111_2222);
    check("R8 hit", 32'(rd_ops - r0), 0);
  endtask

  task automatic t_random();
    logic [31:0] q, a; int r0, d;
    mode_random = 1;
    for (int round = 0; round < 2; round++)
      for (int k = 0; k < 6; k++) begin
        a = 32'hE8 + k * 32'h400;
        r0 = rd_ops;
        access(0, a, 0, 1, q);
        d = rd_ops - r0;
        check("R10 data", q, mem[a[13:2]]);
        check("R10 cost", 32'((d == 0 || d == 8) ? 1 : 0), 1);
      end
    mode_random = 0;
  endtask

  task automatic t_invalidate();
    logic [31:0] q; int r0, w0;
    mode_wback = 1;
    access(0, 32'h100, 0, 1, q);
    access(1, 32'h100, 32'hDEAD_0100, 1, q);
    w0 = wr_ops;
    @(negedge clk) inv_all = 1;
    @(negedge clk) inv_all = 0;
    r0 = rd_ops;
    access(0, 32'h100, 0, 1, q);
    check("R11 refetch", 32'(rd_ops - r0), 8);
    check("R11 no write-back", 32'(wr_ops - w0), 0);
    check("R11 data", q, seed(32'h100 >> 2));
    mode_wback = 0;
  endtask

  task automatic t_handshake();
    logic [31:0] q;
    stall = 1; rsp_ready = 0;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 32'h208; req_cacheable = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    check("R12 busy", 32'(req_ready), 0);
    while (!rsp_valid) @(negedge clk);
    q = rsp_rdata;
    repeat (3) @(negedge clk);
    check("R12 held", 32'(rsp_valid), 1);
    check("R12 stable", rsp_rdata, q);
    check("R12 no accept", 32'(req_ready), 0);
    check("R12 data", q, mem[32'h208 >> 2]);
    rsp_ready = 1;
    @(negedge clk);
    check("R12 released", 32'(rsp_valid), 0);
    stall = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_miss_hit();
    t_write_miss();
    t_write_through();
    t_write_back_rr();
    t_bypass();
    t_random();
    t_invalidate();
    t_handshake();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule